// File: doc/BRIEF.md
# PCM frame program sequencer

The sequencer walks a program of 16-bit command words, one word per PCM word slot, and turns each into a request to the telemetry data path. The two top bits of a command pick the action: sample an analog channel with a chosen gain and offset, read a digital source, insert a sync pattern, or insert a sync pattern and close the major frame by sending the program address back to zero. The major frame is therefore as long as the program up to its closing command, at most 2048 slots.

Timing comes from a one-cycle `bit_tick` strobe per serial bit. A word lasts `word_bits` ticks (6 to 12). On the first bit of each word the block reads the command at `prog_addr` and issues a request. It also raises a word-sync pulse, and a frame-sync pulse when the slot sits at address 0. The block owns two sources that span several slots. The 64-bit time code goes out lowest bits first, one word per slot that selects it. The major-frame counter goes out highest word first. For both, the block fills `req_data` with the slice for the slot.

Requests leave on a valid/ready stream. A request stays on the port, unchanged, until `req_ready` is seen high while `req_valid` is high. If the previous request is still waiting when a new word is due, the word boundary stalls. The bit counter holds on its last bit, no word-sync is given, and the program address holds until the request is taken.

Top module: `pcm_frame_seq`

## Requirements
- R1: `req_kind` carries command bits [15:14]: 00 analog, 01 digital, 10 sync, 11 sync with frame end.
- R2: For an analog command, `req_gain` = bits [13:11], `req_offset` = bits [10:8], `req_sel` = bits [7:0], and `req_data` = 0.
- R3: For a digital command, `req_sel` = bits [7:0] and gain and offset are 0. Codes other than 240 (frame counter) and 241 (time code) give `req_data` = 0.
- R4: For both sync kinds, `req_data` = bits [11:0] shifted right by 12 − `word_bits`, and `req_sel`, gain and offset are 0.
- R5: Each issued slot moves `prog_addr` up by one. After a kind-11 slot, the next slot reads address 0.
- R6: Successive slots selecting 241 carry time-code bits [k·W+W−1 : k·W] for slice k = 0, 1, … (W = `word_bits`). Bits past 63 read as 0.
- R7: The frame counter is L bits long, with L = 24, 21, 24, 27, 20, 22, 24 for W = 6 to 12, split into L/W words. Successive slots selecting 240 carry those words highest first, then start again at the top word.
- R8: The frame counter starts at 0 after reset and goes up by one, modulo 2^L, at each kind-11 slot.
- R9: The slice index restarts at 0 when a slot's command differs from the previous slot's digital select, and when the slot is at address 0.
- R10: A word spans `word_bits` ticks. `word_sync` is high from the tick that starts a word until the next tick, and low otherwise.
- R11: `frame_sync` is high over the same span as `word_sync`, for the word read from address 0 only.
- R12: While `req_valid` is high and `req_ready` is low, all request outputs hold. A due word does not start: `word_sync` stays low and `prog_addr` holds.
- R13: After reset, `prog_addr` = 0 and `req_valid`, `word_sync` and `frame_sync` are 0. The first tick starts a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| word_bits | input | 4 | Bits per word, 6 to 12 |
| prog_addr | output | 11 | Program address being read |
| prog_data | input | 16 | Command word at `prog_addr` (same-cycle read) |
| time_word | input | 64 | Current time code |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Data path accepts the request |
| req_kind | output | 2 | Command kind |
| req_sel | output | 8 | Analog channel or digital source code |
| req_gain | output | 3 | Gain code (analog) |
| req_offset | output | 3 | Offset code (analog) |
| req_data | output | 12 | Sync pattern or multi-word slice, right-aligned |
| word_sync | output | 1 | First-bit-of-word marker |
| frame_sync | output | 1 | First-bit-of-frame marker |

## Verification
All results are registered at the clock edge that sees the starting tick. The request fields, `word_sync`, `frame_sync` and the advanced `prog_addr` are due one cycle after that tick is driven. The bench drives each tick on a falling edge for one cycle and samples on the next falling edge, where it compares against its own model of address, slice index and frame count. Stall behaviour is checked the same way, one cycle after the tick that would have started a word with `req_ready` low. Release is checked one cycle after the ready cycle.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  typedef enum logic [1:0] {
    OP_ANALOG   = 2'b00,
    OP_DIGITAL  = 2'b01,
    OP_SYNC     = 2'b10,
    OP_SYNC_END = 2'b11
  } op_t;

  localparam int unsigned WB_MIN = 6;
  localparam int unsigned WB_MAX = 12;

  function automatic logic [3:0] clamp_wb(input logic [3:0] wb);
    if (wb < 4'(WB_MIN)) return 4'(WB_MIN);
    if (wb > 4'(WB_MAX)) return 4'(WB_MAX);
    return wb;
  endfunction

  function automatic logic [4:0] fc_len(input logic [3:0] wb);
    case (wb)
      4'd7:    return 5'd21;
      4'd9:    return 5'd27;
      4'd10:   return 5'd20;
      4'd11:   return 5'd22;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [2:0] fc_words(input logic [3:0] wb);
    if (wb == 4'd6) return 3'd4;
    if (wb <= 4'd9) return 3'd3;
    return 3'd2;
  endfunction
endpackage

// File: rtl/pcm_seq_decode.sv
module pcm_seq_decode
  import pcm_seq_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int SEL_W = 8,
  parameter int GO_W  = 3,
  parameter int PAT_W = 12
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [3:0]       wb,
  output op_t              op,
  output logic [SEL_W-1:0] sel,
  output logic [GO_W-1:0]  gain,
  output logic [GO_W-1:0]  offset,
  output logic [PAT_W-1:0] pattern
);
  localparam int OFS_LO  = SEL_W;
  localparam int GAIN_LO = SEL_W + GO_W;

  always_comb begin
    op      = op_t'(cmd[CMD_W-1 -: 2]);
    sel     = '0;
    gain    = '0;
    offset  = '0;
    pattern = '0;
    case (op)
      OP_ANALOG: begin
        sel    = cmd[SEL_W-1:0];
        offset = cmd[OFS_LO +: GO_W];
        gain   = cmd[GAIN_LO +: GO_W];
      end
      OP_DIGITAL: sel = cmd[SEL_W-1:0];
      default:    pattern = cmd[PAT_W-1:0] >> (4'(PAT_W) - wb);
    endcase
  end
endmodule

// File: rtl/pcm_seq_timing.sv
module pcm_seq_timing (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [3:0] wb,
  input  logic       hold,
  input  logic       at_origin,
  output logic       word_start,
  output logic       word_sync,
  output logic       frame_sync
);
  logic [3:0] bit_idx;
  logic       idle;
  logic       last_bit;

  assign last_bit   = idle || (bit_idx >= wb - 4'd1);
  assign word_start = bit_tick && last_bit && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx    <= '0;
      idle       <= 1'b1;
      word_sync  <= 1'b0;
      frame_sync <= 1'b0;
    end else if (bit_tick) begin
      if (word_start) begin
        bit_idx <= '0;
        idle    <= 1'b0;
      end else if (!last_bit) begin
        bit_idx <= bit_idx + 4'd1;
      end
      word_sync  <= word_start;
      frame_sync <= word_start && at_origin;
    end
  end

  assert_wsync_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_sync) |-> $past(bit_tick));
  assert_fsync_in_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> word_sync);
endmodule

// File: rtl/pcm_seq_slicer.sv
module pcm_seq_slicer
  import pcm_seq_pkg::*;
#(
  parameter int SEL_W   = 8,
  parameter int DW      = 12,
  parameter int TIME_W  = 64,
  parameter int FC_W    = 27,
  parameter int IDX_W   = 4,
  parameter int FC_CODE = 240,
  parameter int TM_CODE = 241
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_t               op,
  input  logic [SEL_W-1:0]  sel,
  input  logic [3:0]        wb,
  input  logic              at_origin,
  input  logic [TIME_W-1:0] time_word,
  output logic [DW-1:0]     slice_data
);
  localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};

  logic             last_dig;
  logic [SEL_W-1:0] last_sel;
  logic [IDX_W-1:0] idx;
  logic [FC_W-1:0]  fc;

  logic             is_dig, cont, is_fc, is_tm;
  logic [2:0]       nw;
  logic [IDX_W-1:0] idx_use;
  logic [DW-1:0]    mask;
  logic [5:0]       fc_shift;
  logic [7:0]       tm_shift;
  logic [FC_W-1:0]  len_mask;

  always_comb begin
    is_dig   = (op == OP_DIGITAL);
    is_fc    = is_dig && (sel == SEL_W'(FC_CODE));
    is_tm    = is_dig && (sel == SEL_W'(TM_CODE));
    cont     = is_dig && last_dig && (last_sel == sel) && !at_origin;
    nw       = fc_words(wb);
    idx_use  = '0;
    if (cont) begin
      if (is_fc) idx_use = (idx + 1'b1 >= IDX_W'(nw)) ? '0 : idx + 1'b1;
      else       idx_use = (idx == IDX_TOP) ? idx : idx + 1'b1;
    end
    mask     = {DW{1'b1}} >> (4'(DW) - wb);
    fc_shift = 6'((3'(nw - 3'd1) - 3'(idx_use)) * 4'(wb));
    tm_shift = 8'(idx_use) * 8'(wb);
    len_mask = {FC_W{1'b1}} >> (5'(FC_W) - fc_len(wb));
    if (is_fc)      slice_data = DW'(fc >> fc_shift) & mask;
    else if (is_tm) slice_data = DW'(time_word >> tm_shift) & mask;
    else            slice_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_dig <= 1'b0;
      last_sel <= '0;
      idx      <= '0;
      fc       <= '0;
    end else if (start) begin
      last_dig <= is_dig;
      last_sel <= sel;
      idx      <= idx_use;
      if (op == OP_SYNC_END) fc <= (fc + 1'b1) & len_mask;
    end
  end

  assert_fc_slice_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_dig && last_sel == SEL_W'(FC_CODE)) |-> (idx < IDX_W'(fc_words(wb))));
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_seq_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int CMD_W   = 16,
  parameter int SEL_W   = 8,
  parameter int GO_W    = 3,
  parameter int DW      = 12,
  parameter int TIME_W  = 64,
  parameter int FC_CODE = 240,
  parameter int TM_CODE = 241
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [3:0]        word_bits,
  output logic [ADDR_W-1:0] prog_addr,
  input  logic [CMD_W-1:0]  prog_data,
  input  logic [TIME_W-1:0] time_word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_kind,
  output logic [SEL_W-1:0]  req_sel,
  output logic [GO_W-1:0]   req_gain,
  output logic [GO_W-1:0]   req_offset,
  output logic [DW-1:0]     req_data,
  output logic              word_sync,
  output logic              frame_sync
);
  localparam int FC_W = 27;

  logic [3:0]       wb;
  op_t              op;
  logic [SEL_W-1:0] sel;
  logic [GO_W-1:0]  gain, offset;
  logic [DW-1:0]    pattern, slice_data;
  logic             start, pending, at_origin;

  assign wb        = clamp_wb(word_bits);
  assign pending   = req_valid && !req_ready;
  assign at_origin = (prog_addr == '0);

  pcm_seq_decode #(.CMD_W(CMD_W), .SEL_W(SEL_W), .GO_W(GO_W), .PAT_W(DW)) u_dec (
    .cmd(prog_data), .wb(wb), .op(op), .sel(sel),
    .gain(gain), .offset(offset), .pattern(pattern)
  );

  pcm_seq_timing u_tim (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wb(wb), .hold(pending),
    .at_origin(at_origin), .word_start(start),
    .word_sync(word_sync), .frame_sync(frame_sync)
  );

  pcm_seq_slicer #(.SEL_W(SEL_W), .DW(DW), .TIME_W(TIME_W), .FC_W(FC_W),
                   .FC_CODE(FC_CODE), .TM_CODE(TM_CODE)) u_slc (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sel(sel), .wb(wb),
    .at_origin(at_origin), .time_word(time_word), .slice_data(slice_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr  <= '0;
      req_valid  <= 1'b0;
      req_kind   <= '0;
      req_sel    <= '0;
      req_gain   <= '0;
      req_offset <= '0;
      req_data   <= '0;
    end else if (start) begin
      prog_addr  <= (op == OP_SYNC_END) ? '0 : prog_addr + 1'b1;
      req_valid  <= 1'b1;
      req_kind   <= op;
      req_sel    <= sel;
      req_gain   <= gain;
      req_offset <= offset;
      req_data   <= (op == OP_DIGITAL) ? slice_data :
                    (op == OP_ANALOG)  ? '0 : pattern;
    end else if (req_ready) begin
      req_valid  <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_sel)
                                   && $stable(req_data) && $stable(prog_addr)));
  assert_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SYNC_END) |=> (prog_addr == '0));
  assert_sync_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |-> (req_sel == '0 && req_gain == '0));
endmodule

// File: tb/pcm_frame_seq_tb.sv
module pcm_frame_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic [3:0]  word_bits = 4'd8;
  logic [10:0] prog_addr;
  logic [15:0] prog_data;
  logic [63:0] time_word = 64'h0;
  logic        req_valid, req_ready = 1'b1;
  logic [1:0]  req_kind;
  logic [7:0]  req_sel;
  logic [2:0]  req_gain, req_offset;
  logic [11:0] req_data;
  logic        word_sync, frame_sync;

  logic [15:0] prog [0:2047];
  assign prog_data = prog[prog_addr];

  always #10 clk = ~clk;

  pcm_frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_bits(word_bits),
    .prog_addr(prog_addr), .prog_data(prog_data), .time_word(time_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_sel(req_sel), .req_gain(req_gain), .req_offset(req_offset),
    .req_data(req_data), .word_sync(word_sync), .frame_sync(frame_sync)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int     m_addr, m_idx, m_last_dig, m_last_sel;
  longint m_fc;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int fc_len_f(input int w);
    case (w) 7: return 21; 9: return 27; 10: return 20; 11: return 22; default: return 24; endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_addr = 0; m_idx = 0; m_last_dig = 0; m_last_sel = 0; m_fc = 0;
    @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  // One word slot; checks everything due one cycle after its first tick.
  task automatic run_word(input bit full);
    int w, op, sel, nw, idx, cont;
    longint mask, ed, ecmd;
    w = word_bits;
    ecmd = prog[m_addr];
    op = int'(ecmd >> 14) & 3;
    sel = int'(ecmd) & 255;
    mask = (longint'(1) << w) - 1;
    nw = fc_len_f(w) / w;
    cont = (op == 1) && m_last_dig && (m_last_sel == sel) && (m_addr != 0);
    idx = 0;
    if (cont) begin
      if (sel == 240) idx = (m_idx + 1 >= nw) ? 0 : m_idx + 1;
      else idx = (m_idx == 15) ? 15 : m_idx + 1;
    end
    ed = 0;
    if (op >= 2) ed = (ecmd & 12'hFFF) >> (12 - w);
    else if (op == 1 && sel == 240) ed = (m_fc >> ((nw - 1 - idx) * w)) & mask;
    else if (op == 1 && sel == 241) ed = (idx * w >= 64) ? 0 : ((time_word >> (idx * w)) & mask);
    tick();
    chk("R10 word_sync", word_sync, 1);
    chk("R11 frame_sync", frame_sync, m_addr == 0);
    chk("R1 kind", req_kind, op);
    chk("R2/R3 sel", req_sel, op < 2 ? sel : 0);
    chk("R2 gain", req_gain, op == 0 ? (ecmd >> 11) & 7 : 0);
    chk("R2 offset", req_offset, op == 0 ? (ecmd >> 8) & 7 : 0);
    if (op == 1 && (sel == 240 || sel == 241)) chk("R6/R7/R9 slice", req_data, ed);
    else chk("R3/R4 data", req_data, ed);
    m_last_dig = (op == 1); m_last_sel = sel; m_idx = idx;
    if (op == 3) begin
      m_addr = 0;
      m_fc = (m_fc + 1) % (longint'(1) << fc_len_f(w));
    end else m_addr = (m_addr + 1) % 2048;
    chk("R5 prog_addr", prog_addr, m_addr);
    if (full) begin
      for (int b = 1; b < w; b++) tick();
      chk("R10 word_sync low in word", word_sync, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) prog[i] = 16'h8000;
    void'($urandom(32'd12345));
    do_reset();
    // R13 reset state
    chk("R13 prog_addr", prog_addr, 0);
    chk("R13 req_valid", req_valid, 0);
    chk("R13 word_sync", word_sync, 0);
    chk("R13 frame_sync", frame_sync, 0);

    // Directed: async digital, analog gain 7 offset 2 ch 3, closing sync.
    prog[0] = 16'h40FD; prog[1] = 16'h3A03; prog[2] = 16'hCAAA;
    word_bits = 4'd12;
    for (int k = 0; k < 6; k++) run_word(1);
    word_bits = 4'd8;
    do_reset();
    for (int k = 0; k < 3; k++) run_word(1);   // R4 truncated pattern at 8 bits

    // Directed: time code over 7 slots at 10 bits (R6, zero pad past 64).
    word_bits = 4'd10;
    time_word = 64'hFEDC_BA98_7654_3210;
    for (int i = 0; i < 7; i++) prog[i] = 16'h40F1;
    prog[7] = 16'hC123;
    do_reset();
    for (int k = 0; k < 16; k++) run_word(1);

    // Directed: frame counter at 6 bits, 4 slots, 4 frames (R7, R8).
    word_bits = 4'd6;
    for (int i = 0; i < 5; i++) prog[i] = 16'h40F0;
    prog[5] = 16'h40FA; prog[6] = 16'h40F0; prog[7] = 16'hFFFF;
    do_reset();
    for (int k = 0; k < 32; k++) run_word(1);

    // R12 back-pressure stall.
    req_ready = 1'b0;
    run_word(1);
    begin
      logic [10:0] a_hold; logic [11:0] d_hold;
      a_hold = prog_addr; d_hold = req_data;
      tick();
      chk("R12 no word_sync", word_sync, 0);
      chk("R12 valid held", req_valid, 1);
      chk("R12 addr held", prog_addr, a_hold);
      chk("R12 data held", req_data, d_hold);
    end
    req_ready = 1'b1;
    @(negedge clk);
    chk("R12 accepted", req_valid, 0);
    run_word(1);

    // Constrained random programs.
    for (int cfg = 0; cfg < 8; cfg++) begin
      int len;
      word_bits = 4'(6 + ($urandom % 7));
      time_word = {$urandom, $urandom};
      len = 3 + ($urandom % 14);
      for (int i = 0; i < len; i++) begin
        int r; r = $urandom % 8;
        if (r < 2) prog[i] = 16'h40F0;
        else if (r < 4) prog[i] = 16'h40F1;
        else if (r == 4) prog[i] = 16'(16'h4000 | ($urandom % 256));
        else if (r == 5) prog[i] = 16'($urandom % 16384);
        else prog[i] = 16'(16'h8000 | ($urandom % 16384));
      end
      prog[len] = 16'(16'hC000 | ($urandom % 16384));
      do_reset();
      for (int k = 0; k < 3 * (len + 1); k++) run_word(1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule